// File: doc/BRIEF.md
# Terminated Message Streamer with Line-Break Expansion

This block sends a text string held in a byte-wide memory to a serial transmitter, one byte at a time. A start pulse with a base address launches a transfer. The block then reads the memory at the base address and at each following address, and offers each byte on a valid/ready stream to the transmitter.

Two byte values are handled specially. A tilde (0x7E) is not sent. A carriage return (0x0D) followed by a line feed (0x0A) goes out in its place. A zero byte (0x00) ends the string and is not sent. The block reports that it is active on a busy output. It pulses a done output when it reaches the terminator, and an overflow output if the address counter runs off the top of the address space before it finds a terminator.

Top module: `msg_streamer`

## Requirements
- R1: Memory reads are issued at the base address first and then at addresses rising by one per string byte; each read returns its byte on `mem_rdata_i` exactly one cycle after the request.
- R2: A byte of value 0x7E is never sent. It is replaced by two stream bytes: 0x0D first, then 0x0A.
- R3: A byte of value 0x00 ends the transfer and is never sent. `done_o` is high for exactly one cycle, and `busy_o` is already low in that cycle.
- R4: Every byte other than 0x7E and 0x00 appears on `tx_data_o` unchanged, in memory order.
- R5: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` holds its value in the next cycle.
- R6: At most one memory read is outstanding. No read is requested while a byte is waiting on the stream, and a new read is issued only after the previous byte (including both halves of an expansion) has been accepted.
- R7: A start pulse that arrives while `busy_o` is high is ignored. The running transfer continues at its own addresses and produces its own output.
- R8: If the byte at the highest address (all ones) is not 0x00, the block sends it (expanded if it is 0x7E). It then stops without wrapping, pulses `overflow_o` for one cycle with `busy_o` low, and does not raise `done_o`.
- R9: After reset the block is idle: `busy_o`, `tx_valid_o`, `mem_req_o`, `done_o` and `overflow_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled when idle |
| base_addr_i | input | ADDR_W | Address of the first string byte |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | DATA_W | Read data, valid one cycle after the request |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Transmitter accepts the byte |
| tx_data_o | output | DATA_W | Stream byte |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the terminator is reached |
| overflow_o | output | 1 | One-cycle pulse when the address space runs out |

## Verification
The bench builds the block with ADDR_W = 8 instead of the default 16. This makes the address space 256 bytes, so strings that run into the top address can be placed directly. The case where the last byte is a terminator, a tilde or a plain character is then reached in a few cycles, rather than after a 65536-byte walk. DATA_W stays at 8 so that the tilde, zero, CR and LF codes match the requirements exactly.

// File: rtl/msg_stream_pkg.sv
package msg_stream_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_SEND
  } st_e;

  typedef enum logic [1:0] {
    CLS_PLAIN,
    CLS_BREAK,
    CLS_END
  } cls_e;
endpackage

// File: rtl/msg_addr_ctr.sv
module msg_addr_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] TOP = '1;

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= base_i;
    else if (inc_i)  addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == TOP);
endmodule

// File: rtl/msg_char_class.sv
module msg_char_class
  import msg_stream_pkg::*;
#(
  parameter int                 DATA_W     = 8,
  parameter logic [DATA_W-1:0]  BREAK_CHAR = 8'h7E,
  parameter logic [DATA_W-1:0]  END_CHAR   = 8'h00
) (
  input  logic [DATA_W-1:0] byte_i,
  output cls_e              cls_o
);
  always_comb begin
    if (byte_i == END_CHAR)        cls_o = CLS_END;
    else if (byte_i == BREAK_CHAR) cls_o = CLS_BREAK;
    else                           cls_o = CLS_PLAIN;
  end
endmodule

// File: rtl/msg_tx_stage.sv
module msg_tx_stage #(
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-1:0] CR_CHAR = 8'h0D,
  parameter logic [DATA_W-1:0] LF_CHAR = 8'h0A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              expand_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              final_o
);
  logic              valid_q, pend_q;
  logic [DATA_W-1:0] data_q;
  logic              fire;

  assign fire = valid_q && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      pend_q  <= expand_i;
      data_q  <= expand_i ? CR_CHAR : byte_i;
    end else if (fire) begin
      if (pend_q) begin
        data_q <= LF_CHAR;
        pend_q <= 1'b0;
      end else begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign final_o = fire && !pend_q;
endmodule

// File: rtl/msg_streamer.sv
module msg_streamer
  import msg_stream_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] BREAK_CHAR = 8'h7E,
  parameter logic [DATA_W-1:0] END_CHAR   = 8'h00,
  parameter logic [DATA_W-1:0] CR_CHAR    = 8'h0D,
  parameter logic [DATA_W-1:0] LF_CHAR    = 8'h0A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              overflow_o
);
  st_e  st_q, st_d;
  cls_e cls;
  logic ctr_load, ctr_inc, ctr_last;
  logic stg_load, stg_final;
  logic done_q, ovf_q, done_d, ovf_d;

  msg_addr_ctr #(.ADDR_W(ADDR_W)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ctr_load),
    .base_i (base_addr_i),
    .inc_i  (ctr_inc),
    .addr_o (mem_addr_o),
    .last_o (ctr_last)
  );

  msg_char_class #(
    .DATA_W(DATA_W), .BREAK_CHAR(BREAK_CHAR), .END_CHAR(END_CHAR)
  ) i_cls (
    .byte_i (mem_rdata_i),
    .cls_o  (cls)
  );

  msg_tx_stage #(
    .DATA_W(DATA_W), .CR_CHAR(CR_CHAR), .LF_CHAR(LF_CHAR)
  ) i_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (stg_load),
    .byte_i   (mem_rdata_i),
    .expand_i (cls == CLS_BREAK),
    .ready_i  (tx_ready_i),
    .valid_o  (tx_valid_o),
    .data_o   (tx_data_o),
    .final_o  (stg_final)
  );

  always_comb begin
    st_d     = st_q;
    ctr_load = 1'b0;
    ctr_inc  = 1'b0;
    stg_load = 1'b0;
    done_d   = 1'b0;
    ovf_d    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        ctr_load = 1'b1;
        st_d     = ST_FETCH;
      end
      ST_FETCH: st_d = ST_WAIT;
      ST_WAIT: begin
        if (cls == CLS_END) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          stg_load = 1'b1;
          st_d     = ST_SEND;
        end
      end
      ST_SEND: if (stg_final) begin
        // stop at the top of the address space instead of wrapping
        if (ctr_last) begin
          ovf_d = 1'b1;
          st_d  = ST_IDLE;
        end else begin
          ctr_inc = 1'b1;
          st_d    = ST_FETCH;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
    end
  end

  assign mem_req_o  = (st_q == ST_FETCH);
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/msg_streamer_chk.sv
module msg_streamer_chk #(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] BREAK_CHAR = 8'h7E,
  parameter logic [DATA_W-1:0] END_CHAR   = 8'h00
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              overflow_o
);
  a_r5_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  a_r2_no_break_sent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_data_o != BREAK_CHAR);

  a_r3_no_end_sent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_data_o != END_CHAR);

  a_r3_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_ovf_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> !busy_o && !done_o);

  a_r6_no_req_while_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !tx_valid_o);

  a_r6_single_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r1_addr_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mem_req_o && !tx_valid_o |=> $stable(mem_addr_o) || !busy_o || mem_req_o);
endmodule

bind msg_streamer msg_streamer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BREAK_CHAR(BREAK_CHAR), .END_CHAR(END_CHAR)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .overflow_o (overflow_o)
);

// File: tb/test_msg_streamer.sv
`timescale 1ns/1ps
module test_msg_streamer;
  localparam int AW = 8;
  localparam int MW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_addr_i = '0;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_rdata_i = '0;
  logic          tx_valid_o;
  logic          tx_ready_i = 1'b0;
  logic [7:0]    tx_data_o;
  logic          busy_o, done_o, overflow_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [7:0] mem [MW];
  byte unsigned exp_q[$], got_q[$];
  int exp_a[$], got_a[$];
  bit exp_ovf;

  always #2 clk = ~clk;

  msg_streamer #(.ADDR_W(AW), .DATA_W(8)) i_msg_streamer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
    .busy_o(busy_o), .done_o(done_o), .overflow_o(overflow_o)
  );

  // one-cycle read latency memory model
  always @(posedge clk) if (mem_req_o) mem_rdata_i <= mem[mem_addr_o];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  task automatic build_exp(int base);
    int a = base;
    exp_q.delete(); exp_a.delete(); exp_ovf = 0;
    forever begin
      exp_a.push_back(a);
      if (mem[a] == 8'h00) break;
      if (mem[a] == 8'h7E) begin exp_q.push_back(8'h0D); exp_q.push_back(8'h0A); end
      else exp_q.push_back(mem[a]);
      if (a == MW-1) begin exp_ovf = 1; break; end
      a++;
    end
  endtask

  function automatic int first_diff();
    for (int i = 0; i < exp_q.size(); i++)
      if (i >= got_q.size() || got_q[i] != exp_q[i]) return i;
    return (got_q.size() == exp_q.size()) ? -1 : exp_q.size();
  endfunction

  task automatic run_msg(int base, int pct, int inj, string dreq);
    int n = 0, hold_err = 0, ord_err = 0, d;
    bit fin = 0, end_done = 0, end_ovf = 0, busy_end = 1, stall = 0;
    logic [7:0] pdata = '0;
    build_exp(base);
    got_q.delete(); got_a.delete();
    @(negedge clk); start_i = 1; base_addr_i = AW'(base); tx_ready_i = 0;
    @(negedge clk);
    while (!fin && n < 4000) begin
      start_i = (n == inj);
      if (n == inj) base_addr_i = AW'(base ^ 8'h55);
      tx_ready_i = ($urandom % 100) < pct;
      #1;
      if (stall && !(tx_valid_o && tx_data_o == pdata)) hold_err++;
      if (mem_req_o) got_a.push_back(int'(mem_addr_o));
      if (mem_req_o && tx_valid_o) ord_err++;
      if (tx_valid_o && tx_ready_i) got_q.push_back(tx_data_o);
      stall = tx_valid_o && !tx_ready_i; pdata = tx_data_o;
      if (done_o || overflow_o) begin
        fin = 1; end_done = done_o; end_ovf = overflow_o; busy_end = busy_o;
      end
      @(negedge clk); n++;
    end
    start_i = 0; tx_ready_i = 0;
    d = first_diff();
    chk(d < 0, dreq, "stream mismatch at index", d, -1);
    chk(got_q.size() == exp_q.size(), "R4", "stream length", got_q.size(), exp_q.size());
    chk(got_a == exp_a, "R1", "address count", got_a.size(), exp_a.size());
    chk(fin, "R3", "transfer ended", fin, 1);
    if (exp_ovf) begin
      chk(end_ovf && !end_done, "R8", "overflow without done", end_ovf, 1);
    end else begin
      chk(end_done && !end_ovf, "R3", "done without overflow", end_done, 1);
    end
    chk(!busy_end, "R3", "busy low at end pulse", busy_end, 0);
    chk(hold_err == 0, "R5", "stall hold errors", hold_err, 0);
    chk(ord_err == 0, "R6", "read while byte pending", ord_err, 0);
    @(negedge clk);
    chk(!done_o && !overflow_o, "R3", "end pulse one cycle", done_o | overflow_o, 0);
  endtask

  task automatic put_str(int base, string s);
    for (int i = 0; i < s.len(); i++) mem[(base + i) % MW] = s[i];
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < MW; i++) mem[i] = 8'h41;
    #1;
    chk(!busy_o && !tx_valid_o && !mem_req_o && !done_o && !overflow_o,
        "R9", "reset idle", busy_o, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o && !tx_valid_o && !mem_req_o, "R9", "idle after release", busy_o, 0);

    // directed: mixed string with break
    put_str(8'h10, "AB~C"); mem[8'h14] = 8'h00;
    run_msg(8'h10, 100, -1, "R2");
    // immediate terminator
    mem[8'h30] = 8'h00;
    run_msg(8'h30, 100, -1, "R3");
    // back-to-back breaks, slow ready
    put_str(8'h40, "~~"); mem[8'h42] = 8'h00;
    run_msg(8'h40, 30, -1, "R2");
    // plain CR byte and high codes pass through
    mem[8'h50] = 8'h0D; mem[8'h51] = 8'hFF; mem[8'h52] = 8'h7F; mem[8'h53] = 8'h00;
    run_msg(8'h50, 60, -1, "R4");
    // start while busy ignored
    put_str(8'h60, "hello~world"); mem[8'h6B] = 8'h00;
    put_str(8'h60 ^ 8'h55, "ZZ"); mem[(8'h60 ^ 8'h55) + 2] = 8'h00;
    run_msg(8'h60, 50, 5, "R7");
    // runs into top address: plain, break, terminator at top
    put_str(8'hFC, "wxyz");
    run_msg(8'hFC, 70, -1, "R8");
    mem[8'hFF] = 8'h7E;
    run_msg(8'hFD, 70, -1, "R8");
    mem[8'hFF] = 8'h00;
    run_msg(8'hFE, 70, -1, "R3");

    for (int k = 0; k < 24; k++) begin
      int b = $urandom % 200;
      int len = $urandom % 12;
      for (int i = 0; i < len; i++)
        mem[b + i] = (($urandom % 4) == 0) ? 8'h7E : 8'(1 + $urandom % 255);
      mem[b + len] = 8'h00;
      run_msg(b, 20 + $urandom % 81, (k % 3 == 0) ? 2 : -1, "R4");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule